// File: doc/BRIEF.md
# Processor Packet Receive Queue

This block sits between a node's coherence or network logic and its local processor. Packets arrive one 32-bit word per cycle on a ready/valid stream and are held in a circular word store. While at least one complete packet is held, an interrupt line to the processor stays high. When the store is full, the block drops its ready signal, so arriving words wait in the network receive path upstream.

Software handles the packet at the head of the queue. It reads the header and the operand words at any index through a registered load port. It then issues one of two commands. A discard removes the head packet. A store-back copies the head packet into memory, one word per cycle. The copy starts at a chosen word offset inside the packet and goes to a chosen memory address. When the copy ends, the head packet is removed. Packets leave the queue in the order they arrived.

Top module: `rxq_inbox`

## Requirements
- R1: While and after reset, `irq` is 0, `in_ready` is 1, `mem_we` is 0 and `rd_data` is 0.
- R2: A word is taken on each cycle with `in_valid` and `in_ready` both high. The first word of a packet is its header: bits 31:24 hold the source, bits 23:16 the opcode, bits 11:8 the operand count N (0..15) and bits 3:0 the data count M (0..15). The header is followed by N operand words and then M data words, for 1+N+M words in total.
- R3: `irq` rises on the cycle after the last word of a packet is taken. It stays high while any complete packet is held and falls on the cycle after the last packet is removed.
- R4: When all DEPTH word slots hold data, `in_ready` is 0 and no word is taken. `in_ready` returns the cycle after a removal frees slots, and no held word is lost.
- R5: A load with `rd_en` high and index `rd_idx` returns on `rd_data` the cycle after. Index 0 returns the head header and index k (1..N) returns operand k.
- R6: A load whose index is above the head packet's operand count returns 0, and so does any load while the queue is empty.
- R7: A discard (`cmd_valid` high with `cmd_store` at 0) removes the head packet. The next packet in arrival order becomes the head.
- R8: A store-back with offset F < 1+N+M and address A writes packet words F through N+M to addresses A, A+1, and so on. It writes one word per cycle, starting the cycle after the command, and then removes the head packet.
- R9: A store-back whose offset is at least 1+N+M writes nothing and removes the head packet.
- R10: When the last word of an arriving packet is taken in the same cycle the head is removed, the packet count is correct and arrival order is kept.
- R11: A command given while the queue is empty causes no memory write and no removal.
- R12: A command given while a store-back is still copying is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Arriving word is valid |
| in_word | input | 32 | Arriving packet word |
| in_ready | output | 1 | Queue can take a word |
| rd_en | input | 1 | Load request |
| rd_idx | input | 5 | Word index within the head packet |
| rd_data | output | 32 | Load result, one cycle after the request |
| irq | output | 1 | At least one complete packet is held |
| cmd_valid | input | 1 | Command strobe |
| cmd_store | input | 1 | 1 selects store-back, 0 selects discard |
| cmd_off | input | 5 | Store-back starting word offset |
| cmd_addr | input | AW | Store-back base memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | 32 | Memory write data |

## Verification
Two events can land on the same clock edge: the final word of an arriving packet is taken, and the head packet is removed. This case is provoked by driving the last word of a second packet together with a discard of the first. The expected result is that `irq` stays high for exactly one remaining packet and that a header load returns the newer packet. A second collision comes from full-queue backpressure. A word is held stalled while a discard is issued, and the bench checks that `in_ready` recovers and that every word of the stalled packet is later read back in order.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int WORD_W = 32;
    localparam int CNT_W  = 4;
    localparam int LEN_W  = CNT_W + 1;

    typedef enum logic { CMD_DROP = 1'b0, CMD_STORE = 1'b1 } rxq_cmd_e;
    typedef enum logic { DR_IDLE = 1'b0, DR_COPY = 1'b1 } rxq_drain_e;

    function automatic logic [LEN_W-1:0] pkt_words(input logic [CNT_W-1:0] nops,
                                                   input logic [CNT_W-1:0] ndata);
        return LEN_W'(1) + LEN_W'(nops) + LEN_W'(ndata);
    endfunction
endpackage

// File: rtl/rxq_ring.sv
module rxq_ring
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              pop_en,
    input  logic [LEN_W-1:0]  pop_len,
    input  logic [LEN_W-1:0]  ld_off,
    output logic [WORD_W-1:0] ld_word,
    input  logic [LEN_W-1:0]  cp_off,
    output logic [WORD_W-1:0] cp_word,
    output logic [CNT_W-1:0]  head_nops,
    output logic [LEN_W-1:0]  head_len,
    output logic              in_ready
);
    localparam int PW = $clog2(DEPTH);
    localparam int UW = PW + 1;

    logic [WORD_W-1:0] slots [DEPTH];
    logic [PW-1:0]     wr_ptr, rd_ptr;
    logic [UW-1:0]     used;

    always_ff @(posedge clk) begin
        if (wr_en) slots[wr_ptr] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            used   <= '0;
        end else begin
            if (wr_en)  wr_ptr <= wr_ptr + 1'b1;
            if (pop_en) rd_ptr <= rd_ptr + PW'(pop_len);
            used <= used + UW'(wr_en) - (pop_en ? UW'(pop_len) : UW'(0));
        end
    end

    assign ld_word   = slots[rd_ptr + PW'(ld_off)];
    assign cp_word   = slots[rd_ptr + PW'(cp_off)];
    assign head_nops = slots[rd_ptr][11:8];
    assign head_len  = pkt_words(slots[rd_ptr][11:8], slots[rd_ptr][3:0]);
    assign in_ready  = (used != UW'(DEPTH));

    // R4: the intake never writes into a full store
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (used != UW'(DEPTH)));
    // R7: a removal never frees more words than are held
    a_r7_pop_within_used: assert property (@(posedge clk) disable iff (rst)
        pop_en |-> (UW'(pop_len) <= used));
endmodule

// File: rtl/rxq_intake.sv
module rxq_intake
    import rxq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [LEN_W-1:0] first_len,
    output logic             pkt_done
);
    logic [LEN_W-1:0] idx_q, len_q, cur_len;

    assign cur_len  = (idx_q == '0) ? first_len : len_q;
    assign pkt_done = take && (idx_q == cur_len - LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            len_q <= '0;
        end else if (take) begin
            if (idx_q == '0) len_q <= first_len;
            idx_q <= pkt_done ? '0 : idx_q + LEN_W'(1);
        end
    end

    // R2: position inside a packet always stays below that packet's length
    a_r2_idx_in_range: assert property (@(posedge clk) disable iff (rst)
        (idx_q != '0) |-> (idx_q < len_q));
endmodule

// File: rtl/rxq_drain.sv
module rxq_drain
    import rxq_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic             cmd_store,
    input  logic [LEN_W-1:0] cmd_off,
    input  logic [AW-1:0]    cmd_addr,
    input  logic             have_pkt,
    input  logic [LEN_W-1:0] head_len,
    output logic             pop_en,
    output logic [LEN_W-1:0] cp_off,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr
);
    rxq_drain_e       state;
    logic [LEN_W-1:0] cur;
    logic [AW-1:0]    addr_q;
    logic             accept, is_store, last;

    assign accept   = cmd_valid && have_pkt && (state == DR_IDLE);
    assign is_store = (rxq_cmd_e'(cmd_store) == CMD_STORE);
    assign last     = (state == DR_COPY) && (cur == head_len - LEN_W'(1));
    assign pop_en   = (accept && (!is_store || (cmd_off >= head_len))) || last;
    assign mem_we   = (state == DR_COPY);
    assign mem_addr = addr_q;
    assign cp_off   = cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= DR_IDLE;
            cur    <= '0;
            addr_q <= '0;
        end else if (state == DR_IDLE) begin
            if (accept && is_store && (cmd_off < head_len)) begin
                state  <= DR_COPY;
                cur    <= cmd_off;
                addr_q <= cmd_addr;
            end
        end else begin
            cur    <= cur + LEN_W'(1);
            addr_q <= addr_q + 1'b1;
            if (last) state <= DR_IDLE;
        end
    end

    // R8: copying only happens while a head packet exists
    a_r8_we_has_pkt: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> have_pkt);
    // R8: consecutive copy writes use consecutive addresses
    a_r8_addr_step: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1));
endmodule

// File: rtl/rxq_inbox.sv
module rxq_inbox
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              in_ready,
    input  logic              rd_en,
    input  logic [LEN_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    output logic              irq,
    input  logic              cmd_valid,
    input  logic              cmd_store,
    input  logic [LEN_W-1:0]  cmd_off,
    input  logic [AW-1:0]     cmd_addr,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic              take, pkt_done, pop_en, have_pkt;
    logic [LEN_W-1:0]  first_len, head_len, cp_off;
    logic [CNT_W-1:0]  head_nops;
    logic [WORD_W-1:0] ld_word;
    logic [CW-1:0]     pkt_cnt;

    assign take      = in_valid && in_ready;
    assign first_len = pkt_words(in_word[11:8], in_word[3:0]);
    assign have_pkt  = (pkt_cnt != '0);
    assign irq       = have_pkt;

    rxq_ring #(.DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst(rst), .wr_en(take), .wr_word(in_word),
        .pop_en(pop_en), .pop_len(head_len),
        .ld_off(rd_idx), .ld_word(ld_word),
        .cp_off(cp_off), .cp_word(mem_wdata),
        .head_nops(head_nops), .head_len(head_len), .in_ready(in_ready)
    );

    rxq_intake u_intake (
        .clk(clk), .rst(rst), .take(take), .first_len(first_len), .pkt_done(pkt_done)
    );

    rxq_drain #(.AW(AW)) u_drain (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_store(cmd_store),
        .cmd_off(cmd_off), .cmd_addr(cmd_addr), .have_pkt(have_pkt),
        .head_len(head_len), .pop_en(pop_en), .cp_off(cp_off),
        .mem_we(mem_we), .mem_addr(mem_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_cnt <= '0;
            rd_data <= '0;
        end else begin
            pkt_cnt <= pkt_cnt + CW'(pkt_done) - CW'(pop_en);
            if (rd_en)
                rd_data <= (have_pkt && (rd_idx <= {1'b0, head_nops})) ? ld_word : '0;
        end
    end

    // R3: a finished arrival always leaves the interrupt raised
    a_r3_irq_after_arrival: assert property (@(posedge clk) disable iff (rst)
        pkt_done |=> irq);
    // R6: a load past the operand count reads as zero
    a_r6_zero_beyond: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (rd_idx > {1'b0, head_nops})) |=> (rd_data == '0));
    // R4: a stalled input never adds a packet
    a_r4_stall_holds: assert property (@(posedge clk) disable iff (rst)
        !take |=> (pkt_cnt <= $past(pkt_cnt)));
endmodule

// File: tb/tb_rxq_inbox.sv
module tb_rxq_inbox;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_ready;
    logic        rd_en = 1'b0;
    logic [4:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        irq;
    logic        cmd_valid = 1'b0;
    logic        cmd_store = 1'b0;
    logic [4:0]  cmd_off = '0;
    logic [15:0] cmd_addr = '0;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rxq_inbox dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .irq(irq),
        .cmd_valid(cmd_valid), .cmd_store(cmd_store), .cmd_off(cmd_off), .cmd_addr(cmd_addr),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    function automatic logic [31:0] pw(input logic [7:0] tag, input logic [3:0] nops,
                                       input logic [3:0] ndata, input int i);
        if (i == 0) return {tag, 8'h3C, 4'h0, nops, 4'h0, ndata};
        return {8'hA5, tag, 8'h00, 8'(i)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_range(input logic [7:0] tag, input logic [3:0] nops,
                              input logic [3:0] ndata, input int first, input int last);
        for (int i = first; i <= last; i++) begin
            logic acc;
            @(negedge clk);
            in_valid = 1'b1;
            in_word  = pw(tag, nops, ndata, i);
            forever begin
                acc = in_ready;
                @(posedge clk);
                if (acc) break;
                @(negedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_pkt(input logic [7:0] tag, input logic [3:0] nops, input logic [3:0] ndata);
        send_range(tag, nops, ndata, 0, int'(nops) + int'(ndata));
    endtask

    task automatic load(input int idx, output logic [31:0] val);
        @(negedge clk);
        rd_en  = 1'b1;
        rd_idx = 5'(idx);
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        val   = rd_data;
    endtask

    task automatic drop();
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_store = 1'b0;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_store(input logic [7:0] tag, input logic [3:0] nops, input logic [3:0] ndata,
                            input int off, input int base, input int exp_n,
                            input bit interject, input string req);
        int k = 0;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_store = 1'b1;
        cmd_off   = 5'(off);
        cmd_addr  = 16'(base);
        @(posedge clk);
        for (int c = 0; c < 24; c++) begin
            @(negedge clk);
            if (c == 0) cmd_valid = 1'b0;
            if (interject && c == 1) begin cmd_valid = 1'b1; cmd_store = 1'b0; end
            if (interject && c == 2) cmd_valid = 1'b0;
            if (mem_we) begin
                check(mem_addr == 16'(base + k), "R8 addr", {16'h0, mem_addr}, 32'(base + k));
                check(mem_wdata == pw(tag, nops, ndata, off + k), "R8 data",
                      mem_wdata, pw(tag, nops, ndata, off + k));
                k++;
            end
        end
        check(k == exp_n, req, 32'(k), 32'(exp_n));
    endtask

    // R1
    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(irq == 1'b0, "R1 irq", {31'h0, irq}, 0);
        check(in_ready == 1'b1, "R1 ready", {31'h0, in_ready}, 1);
        check(mem_we == 1'b0, "R1 we", {31'h0, mem_we}, 0);
        check(rd_data == '0, "R1 rd_data", rd_data, 0);
        rst = 1'b0;
    endtask

    // R2 R3 R5 R6 R7
    task automatic t_single();
        logic [31:0] v;
        send_pkt(8'h11, 4'd3, 4'd2);
        check(irq == 1'b1, "R3 irq up", {31'h0, irq}, 1);
        load(0, v); check(v == pw(8'h11, 3, 2, 0), "R5 header", v, pw(8'h11, 3, 2, 0));
        load(2, v); check(v == pw(8'h11, 3, 2, 2), "R5 operand", v, pw(8'h11, 3, 2, 2));
        load(3, v); check(v == pw(8'h11, 3, 2, 3), "R2 last operand", v, pw(8'h11, 3, 2, 3));
        load(4, v); check(v == '0, "R6 beyond operands", v, 0);
        drop();
        check(irq == 1'b0, "R3 irq down R7", {31'h0, irq}, 0);
    endtask

    // R11 R6
    task automatic t_empty_cmd();
        logic [31:0] v;
        int writes = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_store = 1'b1; cmd_off = 5'd0; cmd_addr = 16'h0040;
        @(posedge clk);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            if (mem_we) writes++;
        end
        check(writes == 0, "R11 no write", 32'(writes), 0);
        load(0, v); check(v == '0, "R6 empty load", v, 0);
        send_pkt(8'h12, 4'd1, 4'd0);
        load(0, v); check(v == pw(8'h12, 1, 0, 0), "R11 later packet intact", v, pw(8'h12, 1, 0, 0));
        drop();
    endtask

    // R8 R9 R12
    task automatic t_store();
        logic [31:0] v;
        send_pkt(8'h13, 4'd2, 4'd3);
        send_pkt(8'h14, 4'd0, 4'd0);
        do_store(8'h13, 4'd2, 4'd3, 2, 16'h0100, 4, 1'b1, "R12 count with ignored cmd");
        check(irq == 1'b1, "R8 one left", {31'h0, irq}, 1);
        load(0, v); check(v == pw(8'h14, 0, 0, 0), "R12 head after store", v, pw(8'h14, 0, 0, 0));
        do_store(8'h14, 4'd0, 4'd0, 1, 16'h0200, 0, 1'b0, "R9 no write");
        check(irq == 1'b0, "R9 popped", {31'h0, irq}, 0);
    endtask

    // R4
    task automatic t_full();
        logic [31:0] v;
        send_pkt(8'h21, 4'd15, 4'd15);
        send_pkt(8'h22, 4'd15, 4'd15);
        send_range(8'h23, 4'd15, 4'd15, 0, 1);
        in_valid = 1'b1;
        in_word  = pw(8'h23, 15, 15, 2);
        check(in_ready == 1'b0, "R4 full", {31'h0, in_ready}, 0);
        for (int c = 0; c < 3; c++) begin
            @(posedge clk);
            @(negedge clk);
            check(in_ready == 1'b0, "R4 stays full", {31'h0, in_ready}, 0);
        end
        cmd_valid = 1'b1;
        cmd_store = 1'b0;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        in_valid  = 1'b0;
        check(in_ready == 1'b1, "R4 recovers", {31'h0, in_ready}, 1);
        send_range(8'h23, 4'd15, 4'd15, 2, 30);
        load(0, v); check(v == pw(8'h22, 15, 15, 0), "R4 head E", v, pw(8'h22, 15, 15, 0));
        load(15, v); check(v == pw(8'h22, 15, 15, 15), "R4 E operand", v, pw(8'h22, 15, 15, 15));
        drop();
        load(0, v); check(v == pw(8'h23, 15, 15, 0), "R4 head F", v, pw(8'h23, 15, 15, 0));
        load(5, v); check(v == pw(8'h23, 15, 15, 5), "R4 F operand", v, pw(8'h23, 15, 15, 5));
        do_store(8'h23, 4'd15, 4'd15, 28, 16'h0300, 3, 1'b0, "R4 F tail words");
        check(irq == 1'b0, "R4 drained", {31'h0, irq}, 0);
    endtask

    // R10
    task automatic t_collide();
        logic [31:0] v;
        send_pkt(8'h31, 4'd1, 4'd0);
        send_range(8'h32, 4'd2, 4'd1, 0, 2);
        in_valid  = 1'b1;
        in_word   = pw(8'h32, 2, 1, 3);
        cmd_valid = 1'b1;
        cmd_store = 1'b0;
        @(posedge clk);
        @(negedge clk);
        in_valid  = 1'b0;
        cmd_valid = 1'b0;
        check(irq == 1'b1, "R10 one held", {31'h0, irq}, 1);
        load(0, v); check(v == pw(8'h32, 2, 1, 0), "R10 order", v, pw(8'h32, 2, 1, 0));
        load(2, v); check(v == pw(8'h32, 2, 1, 2), "R10 operand", v, pw(8'h32, 2, 1, 2));
        drop();
        check(irq == 1'b0, "R10 empty", {31'h0, irq}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_single();
        t_empty_cmd();
        t_store();
        t_full();
        t_collide();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule